// File: doc/BRIEF.md
# Dual-Channel Interval Down-Counter

This block holds two 16-bit down-counters. Each counter is clocked by enable pulses taken from a shared reference tick. Each channel selects its own tick rate: either every reference tick, or one tick in every 256. The slower rate comes from an 8-bit prescaler that runs all the time.

Each channel also has a mode bit. In one mode the counter wraps from zero to all-ones and keeps counting. In the other it restarts from the last value software wrote. Every time a counter passes through zero, the channel raises a one-cycle interrupt pulse and sets a sticky status bit. Software clears that bit by writing a one to it.

Software reaches the block through a simple register port with a write strobe, a write address and data, and a read address. Reads return data one cycle later. The block itself makes no clocks and routes no interrupts.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and both interrupt outputs are low: control, both counts, both reload values and status. Mode 0 is free-running and select 0 is divide-by-256.
- R2: A write to a channel's count address loads the counter in the next cycle and latches the same value as the reload value. A tick for that channel in the same cycle is ignored.
- R3: In free-running mode (mode bit 0), each enabled tick lowers the count by one. A tick at count 0 sets the count to 0xFFFF.
- R4: In reload mode (mode bit 1), a tick at count 0 sets the count to the value most recently written to that channel.
- R5: With select bit 1 a channel advances on every reference tick. With select bit 0 it advances only on reference ticks whose running number since reset is a multiple of 256, because the prescaler counts every reference tick whatever the select bits hold.
- R6: The control register is at address 0. Bit 4 is channel A's mode, bit 5 channel A's select, bit 6 channel B's mode and bit 7 channel B's select. All other bits read 0.
- R7: Each underflow (a tick at count 0) drives that channel's irq bit high for exactly the following cycle. irq[0] belongs to channel A and irq[1] to channel B.
- R8: The status register is at address 3. Bit 0 (channel A) and bit 1 (channel B) are set by an underflow and stay set until a one is written to that bit. Writing a one clears only the bits written as one.
- R9: Channel A's count is read at address 1 and channel B's at address 2. rd_data is registered, showing the addressed register one cycle after rd_addr is applied. A read changes no state.
- R10: The two channels are independent. Each one's mode, select, count and reload value affect only its own count, irq and status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Shared reference tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 ctrl, 1 count A, 2 count B, 3 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 2 | Per-channel underflow pulse |

## Verification
Channel A runs at the undivided rate and is swept over start values 0 to 4 and tick bursts of 0 to 6, in both modes. The burst lengths reach past zero, so the wrap to 0xFFFF is told apart from the reload of the written value, and the number of irq pulses is compared with the expected underflow count. A long burst then runs with channel A on the divided rate and channel B on the undivided rate in reload mode. This checks the prescaler phase against the bench's own count of reference ticks and shows that the channels do not interact. Directed cases cover a count write that collides with a tick, a clear of one status bit only, repeated reads, and the read-back mask of the control register.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT0   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd3;
  // per-channel control pair: mode at CTRL_LSB+2*i, select at CTRL_LSB+2*i+1
  localparam int CTRL_LSB  = 4;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  output logic div_tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)           pre_q <= '0;
    else if (ref_tick) pre_q <= pre_q + 1'b1;
  end

  assign div_tick = ref_tick && (pre_q == {PRE_W{1'b1}});

  AST_DIV_SPACED: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick); // R5
  AST_DIV_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> ref_tick); // R5
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_mode,
  output logic [CNT_W-1:0] count_o,
  output logic             uf_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             irq_q;

  assign uf_o = tick_en && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= uf_o;
      if (load) begin
        cnt_q <= load_val;
        rld_q <= load_val;
      end else if (tick_en) begin
        if (cnt_q == '0) cnt_q <= reload_mode ? rld_q : {CNT_W{1'b1}};
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load && !reload_mode && cnt_q == '0) |=> cnt_q == {CNT_W{1'b1}}); // R3
  AST_RELOAD_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load && reload_mode && cnt_q == '0) |=> cnt_q == $past(rld_q)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load) |=> $stable(cnt_q)); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(tick_en && !load)); // R7
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        irq
);
  localparam int N_CH   = 2;
  localparam int CTRL_W = 2 * N_CH;

  logic             div_tick;
  logic [CTRL_W-1:0] ctrl_q;
  logic [N_CH-1:0]   status_q, uf, sel, mode, load, clr;
  logic [CNT_W-1:0]  cnt [N_CH];
  logic [DATA_W-1:0] rd_d;
  logic              unused_wr;

  assign unused_wr = ^wr_data;

  tick_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .div_tick(div_tick)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign mode[i] = ctrl_q[2*i];
    assign sel[i]  = ctrl_q[2*i+1];
    assign load[i] = wr_en && (wr_addr == ADR_CNT0 + 2'(i));
    assign clr[i]  = wr_en && (wr_addr == ADR_STATUS) && wr_data[i];

    tmr_channel #(.CNT_W(CNT_W)) i_ch (
      .clk(clk), .rst(rst),
      .tick_en(sel[i] ? ref_tick : div_tick),
      .load(load[i]), .load_val(wr_data[CNT_W-1:0]),
      .reload_mode(mode[i]),
      .count_o(cnt[i]), .uf_o(uf[i]), .irq_o(irq[i])
    );

    always_ff @(posedge clk) begin
      if (rst)        status_q[i] <= 1'b0;
      else if (uf[i]) status_q[i] <= 1'b1;
      else if (clr[i]) status_q[i] <= 1'b0;
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr[i]) |=> status_q[i]); // R8
    AST_STATUS_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> status_q[i]); // R8
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADR_CTRL) ctrl_q <= wr_data[CTRL_LSB +: CTRL_W];
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      ADR_CTRL:   rd_d[CTRL_LSB +: CTRL_W] = ctrl_q;
      ADR_STATUS: rd_d[N_CH-1:0] = status_q;
      default:    rd_d[CNT_W-1:0] = cnt[rd_addr - ADR_CNT0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADR_CTRL) |-> (rd_data[CTRL_LSB-1:0] == '0)); // R6
endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int n_chk = 0, n_bad = 0;
  int tick_total = 0;
  int irq_a = 0, irq_b = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always @(negedge clk) begin
    if (!rst && irq[0]) irq_a++;
    if (!rst && irq[1]) irq_b++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ticks(int k);
    for (int t = 0; t < k; t++) begin
      @(negedge clk);
      ref_tick = 1'b1;
      tick_total++;
    end
    @(negedge clk);
    ref_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int exp_v, exp_n, dv, t0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 count A", d, 0);
    rd(2'd2, d); check("R1 count B", d, 0);
    rd(2'd3, d); check("R1 status", d, 0);
    check("R1 irq", {30'd0, irq}, 0);

    // R6 control mask
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R6 ctrl mask", d, 32'h0000_00F0);

    // Sweep channel A at the undivided rate, both modes (R3 R4 R7 R8)
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 5; v++)
        for (int k = 0; k < 7; k++) begin
          wr(2'd0, (m << 4) | 32'h20);
          wr(2'd3, 32'h3);
          wr(2'd1, v);
          irq_a = 0;
          ticks(k);
          if (m == 0) begin
            exp_v = (v - k) & 16'hFFFF;
            exp_n = (k > v) ? 1 : 0;
          end else begin
            exp_v = v - (k % (v + 1));
            exp_n = k / (v + 1);
          end
          rd(2'd1, d);
          check(m == 0 ? "R3 free count" : "R4 reload count", d, exp_v);
          check("R7 irq pulses", irq_a, exp_n);
          rd(2'd3, d);
          check("R8 status A", {31'd0, d[0]}, (exp_n > 0) ? 1 : 0);
        end

    // R2 load collides with tick
    wr(2'd0, 32'h20);
    wr(2'd1, 10);
    @(negedge clk);
    ref_tick = 1'b1; tick_total++;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 7;
    @(negedge clk);
    ref_tick = 1'b0; wr_en = 1'b0;
    rd(2'd1, d); check("R2 load wins over tick", d, 7);
    // R9 read has no side effect
    rd(2'd1, d2); check("R9 repeat read", d2, 7);

    // R5 R10: A divided free-running, B undivided reload
    wr(2'd0, 32'h0000_00C0);
    wr(2'd3, 32'h3);
    wr(2'd1, 1);
    wr(2'd2, 2);
    irq_a = 0; irq_b = 0;
    t0 = tick_total;
    ticks(600);
    dv = (t0 + 600) / 256 - t0 / 256;
    rd(2'd1, d); check("R5 divided count A", d, (1 - dv) & 16'hFFFF);
    check("R5 divided irq A", irq_a, (dv > 1) ? 1 : 0);
    rd(2'd2, d); check("R10 count B", d, 2 - (600 % 3));
    check("R10 irq B", irq_b, 200);
    rd(2'd3, d); check("R8 status both", d, (dv > 1) ? 3 : 2);
    wr(2'd3, 32'h2);
    rd(2'd3, d); check("R8 clear only B", d, (dv > 1) ? 1 : 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule